// File: doc/BRIEF.md
# Next-Fit Contiguous Page Allocator

This block manages a remapping area of `NUM_PAGES` pages. It keeps one occupancy bit per page in registers. A requester asks for a run of contiguous free pages. The block answers either with the index of the first page of the run or with a failure code. A separate release port hands runs back by start index and length, and the block clears their bits.

The search is next-fit. A roving pointer remembers where the last grant ended, and each new search starts there. The block examines one page per clock. If nothing fits between the pointer and the top of the area, a second pass scans from page zero up to the pointer.

Whenever the allocator may hand out an entry that a translation cache could still hold, it raises a sticky flag telling a flush sequencer to invalidate the cache. This happens when the search wraps, when a grant ends at the top of the area, or on every request in full-flush mode. The flag stays up until the sequencer pulses the clear input. The lowest `RESERVED` pages are a permanently occupied emergency region.

Top module: `nextfit_page_alloc`

## Requirements
- R1: After reset the pages below `RESERVED` (default 32) read as occupied, all other pages are free, the roving pointer is 0, `flushNeeded` is 0 and `reqReady` is 1.
- R2: The first pass looks only at indices from the roving pointer up to `NUM_PAGES-1`. It grants the lowest start whose run of `reqLen` free pages lies wholly in that range.
- R3: When the first pass finds no run, `flushNeeded` is set. A second pass then looks at indices 0 up to the roving pointer minus one, and the granted run must end below the pointer.
- R4: A grant marks its pages occupied and moves the roving pointer to start plus length.
- R5: When start plus length equals `NUM_PAGES`, the pointer becomes 0 and `flushNeeded` is set.
- R6: With `fullFlushMode` high, every accepted request sets `flushNeeded`, whether it succeeds or fails.
- R7: Pages below `RESERVED` are never granted, and a release never frees them.
- R8: A release clears exactly the pages from `relStart` to `relStart+relLen-1` that lie at or above `RESERVED`. A release of length 1 frees a single page.
- R9: A failed request returns `doneStart` with all bits set. `doneStart` is `$clog2(NUM_PAGES)+1` bits wide, so this code never equals a page index.
- R10: A request with `reqLen` of 0 or above `NUM_PAGES` fails in the cycle after it is accepted and changes neither the occupancy nor the pointer.
- R11: `flushNeeded` stays high until a `flushClear` pulse. If a set and a clear arrive in the same cycle, the set wins.
- R12: `reqReady` is high only while no search is in progress. `doneValid` is a one-cycle pulse for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fullFlushMode | input | 1 | Every accepted request sets the flush flag |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Allocator idle, request accepted when valid |
| reqLen | input | IW | Requested run length in pages |
| doneValid | output | 1 | One-cycle result strobe |
| doneStart | output | IW | Granted start index, or all ones on failure |
| relValid | input | 1 | Release strobe |
| relStart | input | IW | First page of the released run |
| relLen | input | IW | Length of the released run |
| flushNeeded | output | 1 | Sticky translation-flush request |
| flushClear | input | 1 | Pulse from the flush sequencer that drops the flag |

## Verification
The hardest case to reach is a second-pass grant. It needs free pages below the roving pointer and none above it. The stimulus first fills the whole area. It then releases a small run high up and takes it back, which parks the pointer near the top. Finally it releases a run low down, so the next request must fail its first pass and succeed on the wrap. A second hard case is a release that overlaps the emergency region. It can only be seen at the ports by a later request that would fit only if the reserved pages had been freed.

// File: rtl/nfa_pkg.sv
package nfa_pkg;
  // Strobes from the sequencing FSM to the allocator datapath
  typedef struct packed {
    logic load;     // capture request, start first pass at rover
    logic restart;  // begin second pass at index 0
    logic step;     // examine current page and advance
    logic grant;    // commit run ending at current page
    logic fail;     // report failure code
  } nfaStrobe_t;
endpackage

// File: rtl/nfa_datapath.sv
module nfa_datapath
  import nfa_pkg::*;
#(
  parameter int NUM_PAGES = 128,
  parameter int RESERVED  = 32,
  parameter int IW        = $clog2(NUM_PAGES) + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  nfaStrobe_t    strb,
  input  logic [IW-1:0] reqLen,
  input  logic          relValid,
  input  logic [IW-1:0] relStart,
  input  logic [IW-1:0] relLen,
  output logic          atLimit,
  output logic          hit,
  output logic          grantWraps,
  output logic [IW-1:0] doneStart
);
  localparam int PW = $clog2(NUM_PAGES);
  localparam int EW = IW + 1;
  localparam logic [IW-1:0] TOP = IW'(NUM_PAGES);

  logic [NUM_PAGES-1:0] occ;
  logic [IW-1:0] rover, pos, runStart, runCount, lenQ;
  logic          pass2;
  logic [IW-1:0] limit, grantStart;
  logic [EW-1:0] grantEnd, relEnd;
  logic          curFree;

  assign limit      = pass2 ? rover : TOP;
  assign atLimit    = pos >= limit;
  assign curFree    = !atLimit && !occ[pos[PW-1:0]];
  assign hit        = curFree && ({1'b0, runCount} + EW'(1) == {1'b0, lenQ});
  assign grantStart = (runCount == '0) ? pos : runStart;
  assign grantEnd   = {1'b0, grantStart} + {1'b0, lenQ};
  assign grantWraps = grantEnd >= EW'(NUM_PAGES);
  assign relEnd     = {1'b0, relStart} + {1'b0, relLen};

  // One occupancy bit per page; reserved pages are constant
  for (genvar i = 0; i < NUM_PAGES; i++) begin : g_page
    if (i < RESERVED) begin : g_rsv
      assign occ[i] = 1'b1;
    end else begin : g_free
      logic inGrant, inRel;
      assign inGrant = strb.grant && (EW'(i) >= {1'b0, grantStart}) && (EW'(i) < grantEnd);
      assign inRel   = relValid && (EW'(i) >= {1'b0, relStart}) && (EW'(i) < relEnd);
      always_ff @(posedge clk) begin
        if (!rstN)        occ[i] <= 1'b0;
        else if (inGrant) occ[i] <= 1'b1;
        else if (inRel)   occ[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rover     <= '0;
      pos       <= '0;
      runStart  <= '0;
      runCount  <= '0;
      lenQ      <= '0;
      pass2     <= 1'b0;
      doneStart <= '0;
    end else begin
      if (strb.load) begin
        pos      <= rover;
        runCount <= '0;
        pass2    <= 1'b0;
        lenQ     <= reqLen;
      end
      if (strb.restart) begin
        pos      <= '0;
        runCount <= '0;
        pass2    <= 1'b1;
      end
      if (strb.step) begin
        pos <= pos + IW'(1);
        if (curFree) begin
          if (runCount == '0) runStart <= pos;
          runCount <= runCount + IW'(1);
        end else begin
          runCount <= '0;
        end
      end
      if (strb.grant) begin
        doneStart <= grantStart;
        rover     <= grantWraps ? '0 : grantEnd[IW-1:0];
      end
      if (strb.fail) doneStart <= '1;
    end
  end
endmodule

// File: rtl/nfa_control.sv
module nfa_control
  import nfa_pkg::*;
#(
  parameter int NUM_PAGES = 128,
  parameter int IW        = $clog2(NUM_PAGES) + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          fullFlushMode,
  input  logic          reqValid,
  input  logic [IW-1:0] reqLen,
  input  logic          flushClear,
  input  logic          atLimit,
  input  logic          hit,
  input  logic          grantWraps,
  output nfaStrobe_t    strb,
  output logic          reqReady,
  output logic          doneValid,
  output logic          flushNeeded
);
  typedef enum logic [1:0] {ST_IDLE, ST_PASS1, ST_PASS2} state_t;
  state_t state, stateNext;
  logic   setFlush, lenBad;

  assign lenBad   = (reqLen == '0) || (reqLen > IW'(NUM_PAGES));
  assign reqReady = (state == ST_IDLE);

  always_comb begin
    strb      = '0;
    setFlush  = 1'b0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          setFlush = fullFlushMode;
          if (lenBad) begin
            strb.fail = 1'b1;
          end else begin
            strb.load = 1'b1;
            stateNext = ST_PASS1;
          end
        end
      end
      ST_PASS1, ST_PASS2: begin
        if (atLimit) begin
          if (state == ST_PASS1) begin
            strb.restart = 1'b1;
            setFlush     = 1'b1;
            stateNext    = ST_PASS2;
          end else begin
            strb.fail = 1'b1;
            stateNext = ST_IDLE;
          end
        end else if (hit) begin
          strb.grant = 1'b1;
          setFlush   = grantWraps;
          stateNext  = ST_IDLE;
        end else begin
          strb.step = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      doneValid   <= 1'b0;
      flushNeeded <= 1'b0;
    end else begin
      state     <= stateNext;
      doneValid <= strb.grant || strb.fail;
      if (setFlush)        flushNeeded <= 1'b1;
      else if (flushClear) flushNeeded <= 1'b0;
    end
  end
endmodule

// File: rtl/nextfit_page_alloc.sv
module nextfit_page_alloc
  import nfa_pkg::*;
#(
  parameter int NUM_PAGES = 128,
  parameter int RESERVED  = 32,
  parameter int IW        = $clog2(NUM_PAGES) + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          fullFlushMode,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic [IW-1:0] reqLen,
  output logic          doneValid,
  output logic [IW-1:0] doneStart,
  input  logic          relValid,
  input  logic [IW-1:0] relStart,
  input  logic [IW-1:0] relLen,
  output logic          flushNeeded,
  input  logic          flushClear
);
  nfaStrobe_t strb;
  logic atLimit, hit, grantWraps;

  nfa_control #(.NUM_PAGES(NUM_PAGES), .IW(IW)) u_ctrl (
    .clk(clk), .rstN(rstN), .fullFlushMode(fullFlushMode),
    .reqValid(reqValid), .reqLen(reqLen), .flushClear(flushClear),
    .atLimit(atLimit), .hit(hit), .grantWraps(grantWraps),
    .strb(strb), .reqReady(reqReady), .doneValid(doneValid),
    .flushNeeded(flushNeeded)
  );

  nfa_datapath #(.NUM_PAGES(NUM_PAGES), .RESERVED(RESERVED), .IW(IW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqLen(reqLen),
    .relValid(relValid), .relStart(relStart), .relLen(relLen),
    .atLimit(atLimit), .hit(hit), .grantWraps(grantWraps),
    .doneStart(doneStart)
  );
endmodule

// File: rtl/nfa_checker.sv
module nfa_checker #(
  parameter int NUM_PAGES = 128,
  parameter int RESERVED  = 32,
  parameter int IW        = $clog2(NUM_PAGES) + 1
) (
  input logic          clk,
  input logic          rstN,
  input logic          fullFlushMode,
  input logic          reqValid,
  input logic          reqReady,
  input logic [IW-1:0] reqLen,
  input logic          doneValid,
  input logic [IW-1:0] doneStart,
  input logic          flushNeeded,
  input logic          flushClear
);
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  p_busy_not_ready_r12: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqLen != '0 && reqLen <= IW'(NUM_PAGES)) |=> !reqReady);

  p_no_reserved_grant_r7: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneStart != '1) |-> (doneStart >= IW'(RESERVED) && doneStart < IW'(NUM_PAGES)));

  p_bad_len_fails_r10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqLen == '0) |=> (doneValid && doneStart == '1));

  p_fullflush_sets_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && fullFlushMode) |=> flushNeeded);

  p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    (flushNeeded && !flushClear) |=> flushNeeded);
endmodule

bind nextfit_page_alloc nfa_checker #(.NUM_PAGES(NUM_PAGES), .RESERVED(RESERVED), .IW(IW)) u_nfa_checker (
  .clk(clk), .rstN(rstN), .fullFlushMode(fullFlushMode), .reqValid(reqValid),
  .reqReady(reqReady), .reqLen(reqLen), .doneValid(doneValid),
  .doneStart(doneStart), .flushNeeded(flushNeeded), .flushClear(flushClear)
);

// File: tb/nextfit_page_alloc_bench.sv
module nextfit_page_alloc_bench;
  localparam int N  = 128;
  localparam int IW = $clog2(N) + 1;
  localparam logic [IW-1:0] FAILV = '1;

  logic clk = 1'b0, rstN = 1'b0;
  logic fullFlushMode = 1'b0, reqValid = 1'b0, relValid = 1'b0, flushClear = 1'b0;
  logic [IW-1:0] reqLen = '0, relStart = '0, relLen = '0;
  logic reqReady, doneValid, flushNeeded;
  logic [IW-1:0] doneStart;
  int checks = 0, fails = 0, cycles = 0;

  always #4 clk = ~clk;

  nextfit_page_alloc #(.NUM_PAGES(N), .RESERVED(32)) u_nextfit_page_alloc (
    .clk(clk), .rstN(rstN), .fullFlushMode(fullFlushMode), .reqValid(reqValid),
    .reqReady(reqReady), .reqLen(reqLen), .doneValid(doneValid),
    .doneStart(doneStart), .relValid(relValid), .relStart(relStart),
    .relLen(relLen), .flushNeeded(flushNeeded), .flushClear(flushClear)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic request(input int len, input int expStart, input string req);
    int waitCnt = 0;
    @(negedge clk);
    reqValid = 1'b1;
    reqLen   = IW'(len);
    @(negedge clk);
    reqValid = 1'b0;
    while (!doneValid && waitCnt < 1000) begin
      @(negedge clk);
      waitCnt++;
    end
    check({req, " done"}, int'(doneValid), 1);
    check({req, " start"}, int'(doneStart), expStart);
  endtask

  task automatic release_run(input int start, input int len);
    @(negedge clk);
    relValid = 1'b1;
    relStart = IW'(start);
    relLen   = IW'(len);
    @(negedge clk);
    relValid = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk);
    flushClear = 1'b1;
    @(negedge clk);
    flushClear = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 ready", int'(reqReady), 1);
    check("R1 flush", int'(flushNeeded), 0);
    check("R12 done idle", int'(doneValid), 0);
  endtask

  task automatic t_first_pass();
    request(4, 32, "R2 first grant after reserved");
    request(8, 36, "R4 rover follows grant");
    check("R2 no flush", int'(flushNeeded), 0);
    release_run(32, 4);
    request(2, 44, "R4 next-fit skips freed run");
  endtask

  task automatic t_bad_len();
    request(0, FAILV, "R10 zero length");
    request(200, FAILV, "R9 too long fails");
    request(1, 46, "R10 pointer unchanged");
  endtask

  task automatic t_top_wrap();
    request(81, 47, "R5 grant to top");
    check("R5 flush on top", int'(flushNeeded), 1);
    @(negedge clk);
    check("R11 sticky", int'(flushNeeded), 1);
    clear_flag();
    check("R11 cleared", int'(flushNeeded), 0);
    request(4, 32, "R5 rover wrapped to zero");
    check("R5 no flush mid", int'(flushNeeded), 0);
  endtask

  task automatic t_full_fail();
    request(1, FAILV, "R9 full area fails");
    check("R3 flush on first-pass miss", int'(flushNeeded), 1);
    clear_flag();
  endtask

  task automatic t_second_pass();
    release_run(100, 3);
    request(3, 100, "R2 high run");
    release_run(40, 4);
    request(4, 40, "R3 second pass grant");
    check("R3 flush set", int'(flushNeeded), 1);
    clear_flag();
    release_run(50, 1);
    request(1, 50, "R8 single page freed");
    request(2, FAILV, "R8 neighbour still used");
    clear_flag();
  endtask

  task automatic t_reserved();
    release_run(0, 40);
    request(10, FAILV, "R7 reserved stays occupied");
    request(8, 32, "R8 partial release freed 32..39");
    clear_flag();
  endtask

  task automatic t_fullflush();
    fullFlushMode = 1'b1;
    release_run(60, 2);
    request(2, 60, "R6 grant in full mode");
    check("R6 flush on success", int'(flushNeeded), 1);
    clear_flag();
    request(0, FAILV, "R6 quick fail");
    check("R6 flush on failure", int'(flushNeeded), 1);
    fullFlushMode = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_pass();
    t_bad_len();
    t_top_wrap();
    t_full_fail();
    t_second_pass();
    t_reserved();
    t_fullflush();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule